// File: doc/BRIEF.md
# Radix-2 Butterfly Custom-Instruction Unit

This block is a multi-cycle coprocessor that a soft CPU reaches through its custom-instruction port. It performs one decimation-in-frequency radix-2 butterfly on complex 16-bit fixed-point data. For operands A and B and twiddle factor W = C + jS it produces D = (A + B)/2 and E = (A − B)·W/2. Halving both outputs keeps them in the same format as the inputs, so they can be written back in place between FFT stages.

Software works through the low three bits of an 11-bit function code, sent with each start strobe:

| Code | Action |
|------|--------|
| 0 | Load operand A |
| 1 | Load operand B |
| 2 | Load C together with C+S |
| 3 | Load C−S and launch the butterfly |
| 4 to 7 | Read back one result word |

The three-coefficient form needs the CPU to precompute C+S and C−S. In return, the twiddle product takes only three multipliers. The multiplier has no pipeline register, so results can be read back soon after the launch. The CPU waits a fixed number of cycles before it takes a result.

Top module: `bfly_ci_unit`

## Requirements
- R1: While rst_n is low at a clock edge, result and every operand, coefficient and output register clear to zero, and a later read returns 0.
- R2: Code 0 loads A and code 1 loads B. The real part comes from dataa[15:0] and the imaginary part from datab[15:0]. Bits 31:16 of both words are ignored.
- R3: Code 2 loads C from dataa[15:0] and C+S from datab[15:0]. Code 3 loads C−S from dataa[15:0] and launches the butterfly. Coefficients are signed with 14 fractional bits.
- R4: For each of the real and imaginary parts, D = (A + B) >>> 1 (arithmetic shift). D becomes readable with a read issued in the second cycle after the launch cycle or later.
- R5: Let X = Are − Bre and Y = Aim − Bim. Then E real = (C·X − S·Y) >>> 15 and E imaginary = (S·X + C·Y) >>> 15, each kept to 16 bits, with the same read timing as R4.
- R6: Codes 4, 5, 6 and 7 place D real, D imaginary, E real and E imaginary on result. The value is sign-extended to 32 bits and appears after the clock edge that ends the start cycle.
- R7: Load codes 0 to 3, and cycles without start, leave result unchanged.
- R8: A start whose prefix has any of bits 10:3 set has no effect on any register.
- R9: When clk_en is low, no register updates: start is ignored and result holds.
- R10: A load issued in the cycle right after a launch does not affect that butterfly. It is used by the next launch.
- R11: A read issued in the cycle right after a launch returns the outputs of the previous butterfly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Enables all register updates |
| start | input | 1 | Strobe that issues one sub-function |
| prefix | input | 11 | Sub-function code |
| dataa | input | 32 | First operand word |
| datab | input | 32 | Second operand word |
| result | output | 32 | Registered read-back word |

## Verification
The butterfly evaluation started by a launch takes place on the same clock edge as whatever command follows the launch directly. That command can be a load of a new operand or a read of an output. The bench provokes both cases: it issues a load of A, and separately a read of D real, in the cycle immediately after code 3. It then checks that the butterfly still used the old A, and that the read returned the previous result. A later launch and read then confirm that the new A did take effect. Both orderings are judged against values the bench computes itself from the arithmetic rules in R4 and R5.

// File: rtl/bfly_pkg.sv
`timescale 1ns/1ps
// bfly_pkg: shared widths, sub-function codes and the complex sample type.
// Assumes the CPU-side word is 32 bits and samples are 16-bit two's complement.
package bfly_pkg;
    localparam int DATA_W  = 16;  // sample width
    localparam int COEF_W  = 16;  // coefficient width
    localparam int COEF_FR = 14;  // coefficient fractional bits
    localparam int PFX_W   = 11;  // prefix port width
    localparam int WORD_W  = 32;  // CPU word width
    localparam int OP_W    = 3;   // decoded sub-function bits

    typedef enum logic [OP_W-1:0] {
        OP_LD_A  = 3'd0,
        OP_LD_B  = 3'd1,
        OP_LD_W1 = 3'd2,
        OP_LD_W2 = 3'd3,
        OP_RD_DR = 3'd4,
        OP_RD_DI = 3'd5,
        OP_RD_ER = 3'd6,
        OP_RD_EI = 3'd7
    } bfly_op_e;

    typedef struct packed {
        logic signed [DATA_W-1:0] re;
        logic signed [DATA_W-1:0] im;
    } cplx_t;
endpackage

// File: rtl/bfly_prefix_dec.sv
`timescale 1ns/1ps
// bfly_prefix_dec: turns a start strobe and prefix into a qualified command.
// Assumes only the low OP_W bits carry a code; any higher bit set voids the command.
module bfly_prefix_dec
    import bfly_pkg::*;
#(
    parameter int PW = PFX_W
) (
    input  logic          start_i,
    input  logic          en_i,
    input  logic [PW-1:0] prefix_i,
    output logic          fire_o,
    output logic          is_rd_o,
    output bfly_op_e      op_o
);
    localparam int HI_W = PW - OP_W;

    logic [HI_W-1:0] hi_bits;
    assign hi_bits = prefix_i[PW-1:OP_W];

    // Qualify the command: strobe, enable, and no stray upper prefix bits.
    always_comb begin
        op_o    = bfly_op_e'(prefix_i[OP_W-1:0]);
        fire_o  = start_i && en_i && (hi_bits == '0);
        is_rd_o = prefix_i[OP_W-1];
    end
endmodule

// File: rtl/bfly_twiddle_mul.sv
`timescale 1ns/1ps
// bfly_twiddle_mul: combinational (X+jY)(C+jS) using three products,
// R = (C-S)Y + C(X-Y), I = (C+S)X - C(X-Y), scaled by 2^-(CF+1).
// Assumes the caller supplies C, C+S and C-S; no pipeline stage inside.
module bfly_twiddle_mul #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int CF = 14
) (
    input  logic signed [DW:0]   x_i,
    input  logic signed [DW:0]   y_i,
    input  logic signed [CW-1:0] c_i,
    input  logic signed [CW-1:0] cps_i,
    input  logic signed [CW-1:0] cms_i,
    output logic signed [DW-1:0] re_o,
    output logic signed [DW-1:0] im_o
);
    localparam int XW = DW + 2;
    localparam int PW = XW + CW;
    localparam int SH = CF + 1;

    logic signed [XW-1:0] xmy;
    logic signed [PW-1:0] p_c, p_r, p_i, re_full, im_full;

    // Shared term C(X-Y) feeds both outputs; the other two products are per-output.
    always_comb begin
        xmy     = XW'(x_i) - XW'(y_i);
        p_c     = PW'(c_i) * PW'(xmy);
        p_r     = PW'(cms_i) * PW'(y_i);
        p_i     = PW'(cps_i) * PW'(x_i);
        re_full = p_r + p_c;
        im_full = p_i - p_c;
        re_o    = re_full[SH +: DW];
        im_o    = im_full[SH +: DW];
    end
endmodule

// File: rtl/bfly_core.sv
`timescale 1ns/1ps
// bfly_core: operand, coefficient and output registers plus the adder,
// subtractor and twiddle multiplier. A launch sets a pending flag; the
// butterfly is captured into the output registers on the next enabled edge.
// Assumes synchronous active-low reset and clk_en as a global update gate.
module bfly_core
    import bfly_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = COEF_W,
    parameter int CF = COEF_FR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          fire_i,
    input  bfly_op_e      op_i,
    input  logic [DW-1:0] wa_i,
    input  logic [DW-1:0] wb_i,
    output cplx_t         d_o,
    output cplx_t         e_o
);
    cplx_t                a_q, b_q;
    logic signed [CW-1:0] c_q, cps_q, cms_q;
    logic                 go_q;

    logic signed [DW:0]   sum_re, sum_im, dif_re, dif_im;
    cplx_t                d_nxt, e_nxt;

    // Adder and subtractor at one guard bit; halving drops the LSB.
    always_comb begin
        sum_re   = (DW+1)'(a_q.re) + (DW+1)'(b_q.re);
        sum_im   = (DW+1)'(a_q.im) + (DW+1)'(b_q.im);
        dif_re   = (DW+1)'(a_q.re) - (DW+1)'(b_q.re);
        dif_im   = (DW+1)'(a_q.im) - (DW+1)'(b_q.im);
        d_nxt.re = sum_re[DW:1];
        d_nxt.im = sum_im[DW:1];
    end

    bfly_twiddle_mul #(.DW(DW), .CW(CW), .CF(CF)) u_tw (
        .x_i   (dif_re),
        .y_i   (dif_im),
        .c_i   (c_q),
        .cps_i (cps_q),
        .cms_i (cms_q),
        .re_o  (e_nxt.re),
        .im_o  (e_nxt.im)
    );

    // Operand/coefficient loads, pending launch, and output capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            c_q   <= '0;
            cps_q <= '0;
            cms_q <= '0;
            go_q  <= 1'b0;
            d_o   <= '0;
            e_o   <= '0;
        end else if (en_i) begin
            if (go_q) begin
                d_o  <= d_nxt;
                e_o  <= e_nxt;
                go_q <= 1'b0;
            end
            if (fire_i) begin
                case (op_i)
                    OP_LD_A:  a_q <= '{re: wa_i, im: wb_i};
                    OP_LD_B:  b_q <= '{re: wa_i, im: wb_i};
                    OP_LD_W1: begin
                        c_q   <= wa_i;
                        cps_q <= wb_i;
                    end
                    OP_LD_W2: begin
                        cms_q <= wa_i;
                        go_q  <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/bfly_ci_unit.sv
`timescale 1ns/1ps
// bfly_ci_unit: custom-instruction wrapper around the butterfly core.
// Decodes the prefix, routes load words to the core and registers the
// selected output word, sign-extended, on result.
// Assumes the CPU holds off reading for at least two cycles after a launch.
module bfly_ci_unit
    import bfly_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int WW = WORD_W,
    parameter int PW = PFX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          start,
    input  logic [PW-1:0] prefix,
    input  logic [WW-1:0] dataa,
    input  logic [WW-1:0] datab,
    output logic [WW-1:0] result
);
    logic     fire, is_rd;
    bfly_op_e op;
    cplx_t    d_w, e_w;
    logic signed [DW-1:0] rd_sel;

    bfly_prefix_dec #(.PW(PW)) u_dec (
        .start_i  (start),
        .en_i     (clk_en),
        .prefix_i (prefix),
        .fire_o   (fire),
        .is_rd_o  (is_rd),
        .op_o     (op)
    );

    bfly_core #(.DW(DW), .CW(COEF_W), .CF(COEF_FR)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (clk_en),
        .fire_i (fire),
        .op_i   (op),
        .wa_i   (dataa[DW-1:0]),
        .wb_i   (datab[DW-1:0]),
        .d_o    (d_w),
        .e_o    (e_w)
    );

    // Read-back selection among the four output halves.
    always_comb begin
        case (op)
            OP_RD_DR: rd_sel = d_w.re;
            OP_RD_DI: rd_sel = d_w.im;
            OP_RD_ER: rd_sel = e_w.re;
            default:  rd_sel = e_w.im;
        endcase
    end

    // Result register: updated only by an accepted read command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (fire && is_rd)
            result <= WW'(rd_sel);
    end
endmodule

// File: rtl/bfly_ci_checker.sv
`timescale 1ns/1ps
// bfly_ci_checker: port-level properties of bfly_ci_unit, bound below.
module bfly_ci_checker #(
    parameter int WW = 32,
    parameter int PW = 11,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          start,
    input logic [PW-1:0] prefix,
    input logic [WW-1:0] result
);
    // R1: a reset edge leaves result at zero.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (result == '0));

    // R6: result always carries a sign-extended sample.
    assert_sign_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (result[WW-1:DW] == {(WW-DW){result[DW-1]}}));

    // R7: load codes do not touch result.
    assert_load_keeps_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && clk_en && prefix < PW'(4)) |=> $stable(result));

    // R7: idle cycles do not touch result.
    assert_idle_keeps_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));

    // R8: stray upper prefix bits void the command.
    assert_bad_prefix_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && prefix[PW-1:3] != '0) |=> $stable(result));

    // R9: disabled clock enable freezes result.
    assert_clk_en_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(result));
endmodule

bind bfly_ci_unit bfly_ci_checker #(.WW(WW), .PW(PW), .DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_en (clk_en),
    .start  (start),
    .prefix (prefix),
    .result (result)
);

// File: tb/bfly_ci_unit_test.sv
`timescale 1ns/1ps
module bfly_ci_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        start = 1'b0;
    logic [10:0] prefix = '0;
    logic [31:0] dataa = '0;
    logic [31:0] datab = '0;
    logic [31:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bfly_ci_unit uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start(start),
        .prefix(prefix), .dataa(dataa), .datab(datab), .result(result)
    );

    function automatic logic [31:0] sx(input longint v);
        logic [15:0] t;
        t = v[15:0];
        return {{16{t[15]}}, t};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge.
    task automatic issue(input logic [10:0] p, input logic [31:0] a, input logic [31:0] b);
        start = 1'b1; prefix = p; dataa = a; datab = b;
        @(negedge clk);
        start = 1'b0; prefix = '0; dataa = '0; datab = '0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] code, output logic [31:0] v);
        issue({8'd0, code}, 32'h0, 32'h0);
        v = result;
    endtask

    task automatic load(input int ar, ai, br, bi, c, s);
        issue(11'd0, {16'hA5A5, 16'(ar)}, {16'h5A5A, 16'(ai)});
        issue(11'd1, {16'hFFFF, 16'(br)}, {16'h1234, 16'(bi)});
        issue(11'd2, 32'(c), 32'(c + s));
        issue(11'd3, 32'(c - s), 32'h0);
    endtask

    task automatic expect_all(input string tag, input int ar, ai, br, bi, c, s);
        longint x, y;
        logic [31:0] v;
        x = ar - br; y = ai - bi;
        rd(3'd4, v); check({tag, " R4 D re"}, v, sx((ar + br) >>> 1));
        rd(3'd5, v); check({tag, " R4 D im"}, v, sx((ai + bi) >>> 1));
        rd(3'd6, v); check({tag, " R5 E re"}, v, sx((c * x - s * y) >>> 15));
        rd(3'd7, v); check({tag, " R5 E im"}, v, sx((s * x + c * y) >>> 15));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 result after reset", result, 32'h0);
        for (int k = 4; k < 8; k++) begin
            rd(3'(k), v);
            check("R1 output reg cleared", v, 32'h0);
        end
    endtask

    task automatic t_bfly(input int ar, ai, br, bi, c, s);
        load(ar, ai, br, bi, c, s);
        idle();
        expect_all("R2 R3 R6", ar, ai, br, bi, c, s);
    endtask

    task automatic t_write_keeps_result();
        logic [31:0] v;
        rd(3'd4, v);
        issue(11'd1, 32'h7777, 32'h8888);
        check("R7 load keeps result", result, v);
        idle();
        check("R7 idle keeps result", result, v);
    endtask

    task automatic t_bad_prefix();
        logic [31:0] v, w;
        load(100, 200, 50, 60, 16384, 0);
        idle();
        rd(3'd4, v);
        issue(11'h008, 32'd3000, 32'd3000);
        issue(11'h40B, 32'd0, 32'd0);
        issue(11'd3, 32'd16384, 32'd0);
        idle();
        rd(3'd4, w);
        check("R8 stray bits ignored (A)", w, sx((100 + 50) >>> 1));
        issue(11'h404, 32'd0, 32'd0);
        check("R8 stray read ignored", result, w);
    endtask

    task automatic t_clk_en();
        logic [31:0] v;
        rd(3'd5, v);
        clk_en = 1'b0;
        issue(11'd6, 32'd0, 32'd0);
        check("R9 read blocked", result, v);
        issue(11'd0, 32'd9000, 32'd9000);
        clk_en = 1'b1;
        issue(11'd3, 32'd16384, 32'd0);
        idle();
        rd(3'd4, v);
        check("R9 load blocked", v, sx((100 + 50) >>> 1));
    endtask

    task automatic t_write_after_trigger();
        logic [31:0] v;
        load(1000, 0, 200, 0, 16384, 0);
        issue(11'd0, 32'd3000, 32'd0);
        idle();
        rd(3'd4, v);
        check("R10 launch used old A", v, sx((1000 + 200) >>> 1));
        issue(11'd3, 32'd16384, 32'd0);
        idle();
        rd(3'd4, v);
        check("R10 next launch uses new A", v, sx((3000 + 200) >>> 1));
    endtask

    task automatic t_read_after_trigger();
        logic [31:0] v;
        issue(11'd0, 32'd5000, 32'd0);
        issue(11'd3, 32'd16384, 32'd0);
        rd(3'd4, v);
        check("R11 read sees previous D", v, sx((3000 + 200) >>> 1));
        rd(3'd4, v);
        check("R11 then new D", v, sx((5000 + 200) >>> 1));
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_bfly(1000, -2000, 300, 400, 11585, -11585);
        t_bfly(-32768, 32767, 32767, -32768, 0, -16384);
        t_bfly(1234, 567, -890, -321, -16384, 0);
        t_bfly(-7, 9, 3, -5, 8000, 12000);
        t_write_keeps_result();
        t_bad_prefix();
        t_clk_en();
        t_write_after_trigger();
        t_read_after_trigger();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule